// File: doc/BRIEF.md
# Instruction-Cycle Trace Buffer

This block keeps a rolling history of an emulated controller's execution. On every instruction cycle that completes while a run is active, a 44-bit snapshot (port pins, program counter, data bus and status lines) is written into a circular store. The store holds the most recent 255 snapshots. Older snapshots are overwritten once the store has wrapped. A saturating counter of captured instruction cycles runs next to the store. Only the host can clear that counter.

A run begins with a start pulse and ends with a stop pulse. The cycle in which stop is seen is still captured. After that the store is frozen. The host then rewinds the read side and pulls entries out one per read strobe, oldest first. It has the fill count and the cycle count available on dedicated outputs. Reads are refused while a run is active.

Top module: `icyc_trace`

## Requirements
- R1: After synchronous reset, `capturing` is 0, `fill_cnt` is 0, `cyc_cnt` is 0 and `rd_valid` is 0.
- R2: While capturing, each cycle with `cyc_stb` high stores `sample` and raises `fill_cnt` by one, until it reaches 255.
- R3: While not capturing, `cyc_stb` has no effect on `fill_cnt`, `cyc_cnt` or the stored entries, and `emu_stop` is ignored.
- R4: A cycle with `emu_stop` and `cyc_stb` both high is captured and is the last entry of the run. `capturing` is low from the next cycle.
- R5: After more than 255 captures in a run, `fill_cnt` stays at 255 and the store holds exactly the 255 most recent samples.
- R6: Once stopped, `rd_rewind` points the read side at the oldest entry. Each `rd_stb` returns the next entry in capture order on `rd_data`, with `rd_valid` high, one cycle later.
- R7: After the newest entry has been read, the next `rd_stb` returns the oldest entry again.
- R8: While capturing, `rd_stb` and `rd_rewind` are ignored and `rd_valid` stays 0.
- R9: `cyc_cnt` increases by one for every captured cycle and holds at 2^CNT_W-1 instead of wrapping.
- R10: `cnt_clr` sets `cyc_cnt` to 0 on the next cycle. It takes priority over a simultaneous increment.
- R11: `emu_start` while idle empties the store (`fill_cnt` becomes 0) but leaves `cyc_cnt` unchanged. While capturing, `emu_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| emu_start | input | 1 | Pulse that begins a run while idle |
| emu_stop | input | 1 | Pulse that ends a run; that cycle is still captured |
| cyc_stb | input | 1 | One instruction cycle has completed |
| sample | input | 44 | Snapshot: port [43:28], program counter [27:16], data [15:8], status [7:0] |
| cnt_clr | input | 1 | Host command that clears the cycle counter |
| rd_rewind | input | 1 | Host command that moves the read side to the oldest entry |
| rd_stb | input | 1 | Host read strobe |
| rd_data | output | 44 | Entry returned by the previous read strobe |
| rd_valid | output | 1 | `rd_data` holds a fresh entry |
| fill_cnt | output | 8 | Number of valid entries (0 to 255) |
| cyc_cnt | output | CNT_W | Saturating instruction-cycle count |
| capturing | output | 1 | A run is active |

## Verification
The hardest case to reach is the wrapped store. The oldest entry is then no longer at slot 0 but at the write position where the run stopped. Readout must walk across the slot 254/0 seam and come back to that position. The stimulus drives 300 strobes with random samples in one run. This puts the seam in the middle of the history. It then reads all 255 entries plus extra reads that wrap. A run of more than 2^CNT_W strobes with a narrowed counter reaches saturation. Clears that coincide with strobes cover the counter priority.

// File: rtl/icyc_trace_pkg.sv
package icyc_trace_pkg;

    typedef struct packed {
        logic [15:0] port;
        logic [11:0] pc;
        logic [7:0]  data;
        logic [7:0]  status;
    } trace_word_t;

    localparam int unsigned SAMPLE_W = $bits(trace_word_t);

    function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/icyc_trace_wr.sv
module icyc_trace_wr #(
    parameter int unsigned DEPTH = 255,
    parameter int unsigned PW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          stb,
    output logic          running,
    output logic          wr_en,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] fill,
    output logic [PW-1:0] oldest
);
    logic running_q;
    logic full_q;
    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            full_q    <= 1'b0;
            ptr_q     <= '0;
        end else if (!running_q) begin
            if (start) begin
                running_q <= 1'b1;
                full_q    <= 1'b0;
                ptr_q     <= '0;
            end
        end else begin
            if (stb) begin
                ptr_q <= PW'(icyc_trace_pkg::wrap_inc(32'(ptr_q), DEPTH));
                if (ptr_q == PW'(DEPTH - 1))
                    full_q <= 1'b1;
            end
            if (stop)
                running_q <= 1'b0;
        end
    end

    assign running = running_q;
    assign wr_en   = running_q && stb;
    assign wr_ptr  = ptr_q;
    assign fill    = full_q ? PW'(DEPTH) : ptr_q;
    assign oldest  = full_q ? ptr_q : '0;

    assert_ptr_range_R5: assert property (@(posedge clk) disable iff (rst)
        ptr_q < PW'(DEPTH));
    assert_full_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (full_q && running_q) |=> full_q);
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!running_q && !start) |=> ($stable(ptr_q) && $stable(full_q) && !running_q));
endmodule

// File: rtl/icyc_trace_ram.sv
module icyc_trace_ram #(
    parameter int unsigned DEPTH = 255,
    parameter int unsigned PW    = 8,
    parameter int unsigned W     = 44
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  q
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (re)
            q <= mem[raddr];
    end
endmodule

// File: rtl/icyc_trace_ctr.sv
module icyc_trace_ctr #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != MAX)
            cnt <= cnt + 1'b1;
    end

    assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt == MAX && !clr) |=> cnt == MAX);
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);
endmodule

// File: rtl/icyc_trace_rd.sv
module icyc_trace_rd #(
    parameter int unsigned DEPTH = 255,
    parameter int unsigned PW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          running,
    input  logic          rewind,
    input  logic          stb,
    input  logic [PW-1:0] fill,
    input  logic [PW-1:0] oldest,
    output logic          re,
    output logic [PW-1:0] raddr,
    output logic          valid
);
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] idx_q;

    assign re    = stb && !running && !rewind && (fill != '0);
    assign raddr = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            idx_q <= '0;
            valid <= 1'b0;
        end else begin
            valid <= re;
            if (!running && rewind) begin
                ptr_q <= oldest;
                idx_q <= '0;
            end else if (re) begin
                if (idx_q >= fill - 1'b1) begin
                    ptr_q <= oldest;
                    idx_q <= '0;
                end else begin
                    ptr_q <= PW'(icyc_trace_pkg::wrap_inc(32'(ptr_q), DEPTH));
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assert_no_read_run_R8: assert property (@(posedge clk) disable iff (rst)
        running |=> !valid);
    assert_addr_range_R6: assert property (@(posedge clk) disable iff (rst)
        ptr_q < PW'(DEPTH));
endmodule

// File: rtl/icyc_trace.sv
module icyc_trace #(
    parameter int unsigned DEPTH = 255,
    parameter int unsigned CNT_W = 20
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                emu_start,
    input  logic                                emu_stop,
    input  logic                                cyc_stb,
    input  logic [icyc_trace_pkg::SAMPLE_W-1:0] sample,
    input  logic                                cnt_clr,
    input  logic                                rd_rewind,
    input  logic                                rd_stb,
    output logic [icyc_trace_pkg::SAMPLE_W-1:0] rd_data,
    output logic                                rd_valid,
    output logic [$clog2(DEPTH+1)-1:0]          fill_cnt,
    output logic [CNT_W-1:0]                    cyc_cnt,
    output logic                                capturing
);
    import icyc_trace_pkg::*;

    localparam int unsigned PW = $clog2(DEPTH + 1);

    trace_word_t   cap_word;
    logic          wr_en;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] oldest;
    logic          rd_en;
    logic [PW-1:0] rd_addr;

    assign cap_word = trace_word_t'(sample);

    icyc_trace_wr #(.DEPTH(DEPTH), .PW(PW)) u_wr (
        .clk(clk), .rst(rst), .start(emu_start), .stop(emu_stop), .stb(cyc_stb),
        .running(capturing), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .fill(fill_cnt), .oldest(oldest)
    );

    icyc_trace_ram #(.DEPTH(DEPTH), .PW(PW), .W(SAMPLE_W)) u_ram (
        .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_ptr), .wdata(cap_word),
        .re(rd_en), .raddr(rd_addr), .q(rd_data)
    );

    icyc_trace_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(wr_en), .cnt(cyc_cnt)
    );

    icyc_trace_rd #(.DEPTH(DEPTH), .PW(PW)) u_rd (
        .clk(clk), .rst(rst), .running(capturing), .rewind(rd_rewind),
        .stb(rd_stb), .fill(fill_cnt), .oldest(oldest),
        .re(rd_en), .raddr(rd_addr), .valid(rd_valid)
    );

    assert_fill_step_R2: assert property (@(posedge clk) disable iff (rst)
        (capturing && cyc_stb && fill_cnt < PW'(DEPTH)) |=> fill_cnt == $past(fill_cnt) + 1'b1);
    assert_stop_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (capturing && emu_stop) |=> !capturing);
endmodule

// File: tb/test_icyc_trace.sv
`timescale 1ns/1ps
module test_icyc_trace;
    localparam int CW  = 10;
    localparam int DEP = 255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic emu_start = 0, emu_stop = 0, cyc_stb = 0, cnt_clr = 0, rd_rewind = 0, rd_stb = 0;
    logic [43:0] sample = '0;
    logic [43:0] rd_data;
    logic        rd_valid;
    logic [7:0]  fill_cnt;
    logic [CW-1:0] cyc_cnt;
    logic        capturing;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [43:0] model_q[$];
    logic [43:0] exp_q[$];
    bit m_run = 0;
    int m_cnt = 0;
    int m_ridx = 0;

    always #10 clk = ~clk;

    icyc_trace #(.DEPTH(DEP), .CNT_W(CW)) i_icyc_trace (
        .clk(clk), .rst(rst), .emu_start(emu_start), .emu_stop(emu_stop),
        .cyc_stb(cyc_stb), .sample(sample), .cnt_clr(cnt_clr),
        .rd_rewind(rd_rewind), .rd_stb(rd_stb), .rd_data(rd_data),
        .rd_valid(rd_valid), .fill_cnt(fill_cnt), .cyc_cnt(cyc_cnt),
        .capturing(capturing)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and updates the reference model
    task automatic step(input bit st, input bit sp, input bit sb, input bit clr,
                        input bit rew, input bit rd, input logic [43:0] d);
        bit was_run;
        was_run = m_run;
        emu_start = st; emu_stop = sp; cyc_stb = sb; cnt_clr = clr;
        rd_rewind = rew; rd_stb = rd; sample = d;
        if (clr) m_cnt = 0;
        else if (was_run && sb && m_cnt < (1 << CW) - 1) m_cnt++;
        if (!was_run) begin
            if (st) begin m_run = 1; model_q.delete(); end
            if (rew) m_ridx = 0;
            else if (rd && model_q.size() > 0) begin
                exp_q.push_back(model_q[m_ridx]);
                m_ridx = (m_ridx + 1) % model_q.size();
            end
        end else begin
            if (sb) begin
                model_q.push_back(d);
                if (model_q.size() > DEP) void'(model_q.pop_front());
            end
            if (sp) m_run = 0;
        end
        @(negedge clk);
        emu_start = 0; emu_stop = 0; cyc_stb = 0; cnt_clr = 0;
        rd_rewind = 0; rd_stb = 0;
    endtask

    function automatic logic [43:0] rnd();
        return {$urandom, $urandom} & 44'hFFF_FFFF_FFFF;
    endfunction

    // monitor: pops expected entries as the design returns them
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R8 actual=rd_valid=1 expected=rd_valid=0");
            end else begin
                logic [43:0] e;
                e = exp_q.pop_front();
                check("R6 readout data", rd_data, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 capturing", capturing, 0);
        check("R1 fill", fill_cnt, 0);
        check("R1 cyc_cnt", cyc_cnt, 0);
        check("R1 rd_valid", rd_valid, 0);

        // R3 strobes and stop while idle are ignored
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 0, 0, rnd());
        check("R3 fill idle", fill_cnt, 0);
        check("R3 cnt idle", cyc_cnt, 0);

        // short run with gaps; R4 stop cycle captured
        step(1, 0, 0, 0, 0, 0, '0);
        check("R11 capturing", capturing, 1);
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 1, 0, 0, 0, rnd());
            step(0, 0, 0, 0, 0, 0, rnd());
        end
        check("R2 fill", fill_cnt, 5);
        check("R9 count", cyc_cnt, 5);
        step(0, 1, 1, 0, 0, 0, rnd());
        check("R4 stopped", capturing, 0);
        check("R4 fill", fill_cnt, 6);

        // R6 readout oldest first, R7 wrap past newest
        step(0, 0, 0, 0, 1, 0, '0);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 1, '0);
        step(0, 0, 0, 0, 0, 0, '0);
        check("R7 all reads returned", exp_q.size(), 0);

        // R3 strobe after stop has no effect
        step(0, 0, 1, 0, 0, 0, rnd());
        check("R3 fill frozen", fill_cnt, 6);
        check("R3 cnt frozen", cyc_cnt, 6);

        // R11 start empties store, keeps counter; R8 reads refused while running
        step(1, 0, 0, 0, 0, 0, '0);
        check("R11 fill cleared", fill_cnt, 0);
        check("R11 cnt kept", cyc_cnt, 6);
        step(0, 0, 1, 0, 1, 1, rnd());
        check("R8 no valid", rd_valid, 0);
        step(1, 0, 1, 0, 0, 0, rnd());
        check("R11 start ignored running", fill_cnt, 2);
        for (int i = 0; i < 298; i++) step(0, 0, 1, 0, 0, 0, rnd());
        check("R5 fill saturates", fill_cnt, 255);
        check("R9 count", cyc_cnt, m_cnt);
        step(0, 1, 0, 0, 0, 0, '0);
        check("R5 fill after stop", fill_cnt, 255);

        // R5/R6 read wrapped history, then R7 extra reads
        step(0, 0, 0, 0, 1, 0, '0);
        for (int i = 0; i < 258; i++) step(0, 0, 0, 0, 0, 1, '0);
        step(0, 0, 0, 0, 1, 0, '0);
        step(0, 0, 0, 0, 0, 1, '0);
        step(0, 0, 0, 0, 0, 0, '0);
        check("R5 all reads returned", exp_q.size(), 0);

        // R10 clear, and priority over increment
        step(0, 0, 0, 1, 0, 0, '0);
        check("R10 clear", cyc_cnt, 0);
        step(1, 0, 0, 0, 0, 0, '0);
        step(0, 0, 1, 0, 0, 0, rnd());
        step(0, 0, 1, 1, 0, 0, rnd());
        check("R10 clear wins", cyc_cnt, 0);

        // R9 saturation
        for (int i = 0; i < 1030; i++) step(0, 0, 1, 0, 0, 0, rnd());
        check("R9 saturated", cyc_cnt, (1 << CW) - 1);
        step(0, 1, 1, 0, 0, 0, rnd());
        check("R9 held", cyc_cnt, (1 << CW) - 1);
        check("R5 fill", fill_cnt, 255);

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule